// File: doc/BRIEF.md
# Grouped Interrupt Router

This block gathers 64 interrupt request lines, brings each into the local clock domain, and applies a selectable active sense to each line. It then latches the active level into a status bit. A 16-by-64 membership matrix gives each of 16 group output lines its own subset of inputs. A group line rises while any of its members is latched and enabled. One input may belong to any number of groups, and then every one of those groups fires.

Software reaches every register over a plain 32-bit read/write bus with a byte address. Every per-input register is a 64-bit pair: the word at the pair's base holds inputs 0 to 31 and the word 4 bytes above holds inputs 32 to 63. A handler reads the group status view of its own group to find which member raised the request. It acknowledges by writing ones to the status register. Nothing is routed out of reset, because all membership bits come up clear.

Top module: `irq_router_top`

## Requirements
- R1: After reset, the enable, polarity, wake enable, stage-one enable, status and all group membership registers read zero, and every group output is low.
- R2: Register pair k sits at byte offset 8*k. The pairs are: raw input 0, status 1, enable 2, polarity 3, wake enable 4, reserved 5, stage-one enable 6, software trigger 7, group g membership 8+g, group g status 24+g. Address bit 2 selects the high word (inputs 32 to 63). Read data appears one cycle after the read strobe and is marked by busRdValid.
- R3: With polarity bit 0 an input is active when high. With polarity bit 1 it is active when low. An active input sets its status bit after two synchronizer stages plus the latch, which is three clock edges.
- R4: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. The bit stays set while its input remains active. It stays latched after the input goes inactive.
- R5: Writing 1 to a software trigger bit sets the matching status bit. The trigger register reads zero.
- R6: Group output g is registered and goes high one edge after some input has its status, enable and group g membership bits all set.
- R7: An input that is a member of several groups drives all of those group outputs at once.
- R8: A group status word reads the status bits ANDed with that group's membership, regardless of enable.
- R9: The reserved pair reads zero and ignores writes. Writes to the raw input register and to group status registers have no effect.
- R10: The raw input register reads the synchronized input levels before polarity is applied.
- R11: The wake enable, stage-one enable, enable, polarity and membership registers read back the last value written to each word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one cycle per word |
| busRdEn | input | 1 | Read strobe, one cycle per word |
| busAddr | input | 9 | Byte address of the 32-bit word |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid with busRdValid |
| busRdValid | output | 1 | Read data valid, one cycle after busRdEn |
| irqIn | input | 64 | Asynchronous interrupt request lines |
| irqOut | output | 16 | One interrupt line per group |

## Verification
The hardest case to reach is an acknowledge that arrives while the source is still active. The clear and the re-latch then land on the same edge, and the set must win. The stimulus holds an input active, writes its status bit with a one, and reads the status back. Only after that does it drop the input, wait out the synchronizer, and clear again. A second hard case is one input shared by two groups, plus a member whose enable is dropped. Both outputs are observed, and the group status view is read while the output is masked.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [3:0] {
    K_INPUT,
    K_STATUS,
    K_ENABLE,
    K_POL,
    K_WAKE,
    K_RSVD,
    K_STAGE1,
    K_SWTRIG,
    K_GROUP,
    K_GSTAT,
    K_NONE
  } regKind_e;

  typedef struct packed {
    logic     wr;
    logic     rd;
    regKind_e kind;
    logic [3:0] grp;
    logic     hiWord;
  } busStrobe_t;

  // pair indices that fix the address map
  localparam int unsigned PAIR_GROUP_BASE = 8;
  localparam int unsigned PAIR_GSTAT_BASE = 24;
  localparam int unsigned PAIR_END        = 40;

endpackage

// File: rtl/irq_router_sync.sv
module irq_router_sync #(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int unsigned ADDR_W  = 9,
  parameter int unsigned NUM_GRP = 16
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        stb
);

  localparam int unsigned PAIR_W = ADDR_W - 3;

  logic [PAIR_W-1:0] pairIdx;
  assign pairIdx = busAddr[ADDR_W-1:3];

  always_comb begin
    stb        = '0;
    stb.wr     = busWrEn;
    stb.rd     = busRdEn;
    stb.hiWord = busAddr[2];
    stb.kind   = K_NONE;
    if (32'(pairIdx) < PAIR_GROUP_BASE) begin
      unique case (pairIdx[2:0])
        3'd0: stb.kind = K_INPUT;
        3'd1: stb.kind = K_STATUS;
        3'd2: stb.kind = K_ENABLE;
        3'd3: stb.kind = K_POL;
        3'd4: stb.kind = K_WAKE;
        3'd5: stb.kind = K_RSVD;
        3'd6: stb.kind = K_STAGE1;
        default: stb.kind = K_SWTRIG;
      endcase
    end else if (32'(pairIdx) < PAIR_GROUP_BASE + NUM_GRP) begin
      stb.kind = K_GROUP;
      stb.grp  = 4'(32'(pairIdx) - PAIR_GROUP_BASE);
    end else if (32'(pairIdx) < PAIR_GSTAT_BASE + NUM_GRP) begin
      stb.kind = K_GSTAT;
      stb.grp  = 4'(32'(pairIdx) - PAIR_GSTAT_BASE);
    end
  end

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_IN  = 64,
  parameter int unsigned NUM_GRP = 16,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrobe_t         stb,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic               busRdValid,
  input  logic [NUM_IN-1:0]  irqIn,
  output logic [NUM_GRP-1:0] irqOut
);

  localparam int unsigned WORD_W = NUM_IN / 2;

  logic [NUM_IN-1:0] syncIn, activeLvl;
  logic [NUM_IN-1:0] statusReg, enableReg, polReg, wakeReg, stage1Reg;
  logic [NUM_IN-1:0] memberReg [NUM_GRP];
  logic [NUM_IN-1:0] wordMask, clrMask, swSet, rdPair;
  logic [NUM_GRP-1:0] groupHit;

  irq_router_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (irqIn),
    .syncOut (syncIn)
  );

  // polarity conditioning: 1 selects active-low
  assign activeLvl = syncIn ^ polReg;

  // write data placed into the addressed half of a pair
  assign wordMask = stb.hiWord ? {busWrData[WORD_W-1:0], {WORD_W{1'b0}}}
                               : {{WORD_W{1'b0}}, busWrData[WORD_W-1:0]};
  assign clrMask  = (stb.wr && stb.kind == K_STATUS) ? wordMask : '0;
  assign swSet    = (stb.wr && stb.kind == K_SWTRIG) ? wordMask : '0;

  function automatic logic [NUM_IN-1:0] mergeWord(
    input logic [NUM_IN-1:0] old, input logic hi, input logic [31:0] d);
    logic [NUM_IN-1:0] r;
    r = old;
    if (hi) r[NUM_IN-1:WORD_W] = d[WORD_W-1:0];
    else    r[WORD_W-1:0]      = d[WORD_W-1:0];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= (statusReg & ~clrMask) | activeLvl | swSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= '0;
      polReg    <= '0;
      wakeReg   <= '0;
      stage1Reg <= '0;
    end else if (stb.wr) begin
      unique case (stb.kind)
        K_ENABLE: enableReg <= mergeWord(enableReg, stb.hiWord, busWrData);
        K_POL:    polReg    <= mergeWord(polReg,    stb.hiWord, busWrData);
        K_WAKE:   wakeReg   <= mergeWord(wakeReg,   stb.hiWord, busWrData);
        K_STAGE1: stage1Reg <= mergeWord(stage1Reg, stb.hiWord, busWrData);
        default: ;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) memberReg[g] <= '0;
        else if (stb.wr && stb.kind == K_GROUP && 32'(stb.grp) == g)
          memberReg[g] <= mergeWord(memberReg[g], stb.hiWord, busWrData);
      end
      assign groupHit[g] = |(statusReg & enableReg & memberReg[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= '0;
    else       irqOut <= groupHit;
  end

  always_comb begin
    unique case (stb.kind)
      K_INPUT:  rdPair = syncIn;
      K_STATUS: rdPair = statusReg;
      K_ENABLE: rdPair = enableReg;
      K_POL:    rdPair = polReg;
      K_WAKE:   rdPair = wakeReg;
      K_STAGE1: rdPair = stage1Reg;
      K_GROUP:  rdPair = memberReg[stb.grp];
      K_GSTAT:  rdPair = statusReg & memberReg[stb.grp];
      default:  rdPair = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData  <= '0;
      busRdValid <= 1'b0;
    end else begin
      busRdValid <= stb.rd;
      if (stb.rd)
        busRdData <= 32'(stb.hiWord ? rdPair[NUM_IN-1:WORD_W] : rdPair[WORD_W-1:0]);
    end
  end

  // R4
  status_no_silent_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wr && stb.kind == K_STATUS) |=> ((statusReg & $past(statusReg)) == $past(statusReg)));

  // R6
  no_out_when_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enableReg == '0) |=> (irqOut == '0));

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rd |=> busRdValid);

  // R9
  reserved_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && stb.kind == K_RSVD) |=> (busRdData == '0));

endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_IN  = 64,
  parameter int unsigned NUM_GRP = 16,
  parameter int unsigned ADDR_W  = 9,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic               busRdValid,
  input  logic [NUM_IN-1:0]  irqIn,
  output logic [NUM_GRP-1:0] irqOut
);

  busStrobe_t stb;

  irq_router_ctrl #(.ADDR_W(ADDR_W), .NUM_GRP(NUM_GRP)) u_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .stb     (stb)
  );

  irq_router_dp #(.NUM_IN(NUM_IN), .NUM_GRP(NUM_GRP), .SYNC_N(SYNC_N)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .busRdValid (busRdValid),
    .irqIn      (irqIn),
    .irqOut     (irqOut)
  );

endmodule

// File: tb/irq_router_top_tb.sv
`timescale 1ns/1ps
module irq_router_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [8:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busRdValid;
  logic [63:0] irqIn = '0;
  logic [15:0] irqOut;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  irq_router_top u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busRdValid(busRdValid), .irqIn(irqIn), .irqOut(irqOut)
  );

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      checkCnt++;
      if (expQ.size() == 0) begin
        failCnt++;
        $display("FAIL R2 unexpected read data: actual %h expected none", busRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdData !== e) begin
          failCnt++;
          $display("FAIL %s read: actual %h expected %h", t, busRdData, e);
        end
      end
    end
  end

  task automatic busWrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [8:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic checkIrq(input logic [15:0] e, input string t);
    @(negedge clk);
    checkCnt++;
    if (irqOut !== e) begin
      failCnt++;
      $display("FAIL %s irqOut: actual %h expected %h", t, irqOut, e);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    #200000;
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);

    // R1 reset state
    checkIrq(16'h0000, "R1");
    busRead(9'h010, 32'h0, "R1 enable");
    busRead(9'h018, 32'h0, "R1 polarity");
    busRead(9'h024, 32'h0, "R1 wake");
    busRead(9'h030, 32'h0, "R1 stage1");
    busRead(9'h008, 32'h0, "R1 status");
    busRead(9'h040, 32'h0, "R1 group0");
    busRead(9'h0BC, 32'h0, "R1 group15 hi");

    // routing: input 6 in groups 2 and 5, input 40 in group 1
    busWrite(9'h010, 32'hFFFF_FFFF);
    busWrite(9'h014, 32'hFFFF_FFFF);
    busWrite(9'h050, 32'h0000_0040);
    busWrite(9'h068, 32'h0000_0040);
    busWrite(9'h04C, 32'h0000_0100);
    busRead(9'h050, 32'h0000_0040, "R11 group2");
    busRead(9'h04C, 32'h0000_0100, "R2 group1 hi");

    // R3 active-high input, R7 shared membership
    irqIn[6] = 1'b1;
    waitCycles(6);
    checkIrq(16'h0024, "R7");
    busRead(9'h008, 32'h0000_0040, "R3 status");
    busRead(9'h0D0, 32'h0000_0040, "R8 gstat2");
    busRead(9'h0C8, 32'h0000_0000, "R8 gstat1");
    busRead(9'h000, 32'h0000_0040, "R10 raw input");

    // R4 acknowledge while source still active
    busWrite(9'h008, 32'h0000_0040);
    busRead(9'h008, 32'h0000_0040, "R4 held");
    irqIn[6] = 1'b0;
    waitCycles(5);
    busRead(9'h008, 32'h0000_0040, "R4 latched");
    busWrite(9'h008, 32'h0000_0000);
    busRead(9'h008, 32'h0000_0040, "R4 zero write");
    busWrite(9'h008, 32'h0000_0040);
    busRead(9'h008, 32'h0000_0000, "R4 cleared");
    waitCycles(2);
    checkIrq(16'h0000, "R6 after clear");

    // R3 active-low input 40
    busWrite(9'h01C, 32'h0000_0100);
    waitCycles(5);
    busRead(9'h00C, 32'h0000_0100, "R3 active low");
    checkIrq(16'h0002, "R6 group1");
    busRead(9'h004, 32'h0000_0000, "R10 raw before polarity");
    irqIn[40] = 1'b1;
    waitCycles(5);
    busWrite(9'h00C, 32'h0000_0100);
    busRead(9'h00C, 32'h0000_0000, "R3 inactive high");
    waitCycles(2);
    checkIrq(16'h0000, "R6 group1 idle");

    // R5 software trigger on input 3
    busWrite(9'h038, 32'h0000_0008);
    busRead(9'h008, 32'h0000_0008, "R5 status set");
    busRead(9'h038, 32'h0000_0000, "R5 reads zero");
    checkIrq(16'h0000, "R6 no member");
    busWrite(9'h040, 32'h0000_0008);
    waitCycles(2);
    checkIrq(16'h0001, "R6 group0");
    busRead(9'h0C0, 32'h0000_0008, "R8 gstat0");
    busWrite(9'h010, 32'h0000_0000);
    waitCycles(2);
    checkIrq(16'h0000, "R6 disabled");
    busRead(9'h0C0, 32'h0000_0008, "R8 gstat ignores enable");
    busWrite(9'h008, 32'h0000_0008);
    busRead(9'h008, 32'h0000_0000, "R4 clear sw");

    // R9 reserved and read-only registers
    busWrite(9'h028, 32'hDEAD_BEEF);
    busRead(9'h028, 32'h0000_0000, "R9 reserved");
    busWrite(9'h000, 32'hFFFF_FFFF);
    busRead(9'h000, 32'h0000_0000, "R9 input ro");
    busWrite(9'h0C0, 32'hFFFF_FFFF);
    busRead(9'h0C0, 32'h0000_0000, "R9 gstat ro");

    // R11 plain storage, R2 far offsets
    busWrite(9'h020, 32'h1234_5678);
    busWrite(9'h034, 32'hA5A5_0F0F);
    busWrite(9'h0BC, 32'h0000_00F0);
    busRead(9'h020, 32'h1234_5678, "R11 wake");
    busRead(9'h034, 32'hA5A5_0F0F, "R11 stage1 hi");
    busRead(9'h0BC, 32'h0000_00F0, "R2 group15 hi");
    busRead(9'h13C, 32'h0000_0000, "R2 gstat15 hi");

    waitCycles(4);
    checkCnt++;
    if (expQ.size() != 0) begin
      failCnt++;
      $display("FAIL R2 missing reads: actual %0d pending expected 0", expQ.size());
    end
    finishRun();
  end

endmodule